// File: doc/BRIEF.md
# Reservation Station Pool with Broadcast Tag Snooping

This block holds the instructions waiting for one functional unit of an out-of-order core. An in-order issue stage hands it an operation, a destination tag (the reorder-buffer index of the instruction) and two source operands. Each operand comes either as a finished value or as the tag of the instruction that will produce it. Each station keeps a value and a producer tag per operand. While a tag is outstanding, the station compares it with every result broadcast and takes the broadcast value when the tags match.

Once both operands of a station hold values, the station may be sent to the functional unit. If several stations are ready, the oldest one goes, and only one goes per cycle. A dispatched station stays occupied until its own destination tag shows up on the broadcast bus. Only then can a new issue reuse it. When every station is occupied, the issue handshake drops so that the issue stage stalls. A flush empties the pool in one cycle. The register file, the rename table, the functional unit and the bus arbitration all sit outside the block.

Top module: `rs_pool`

## Requirements
- R1: In the first cycle after a synchronous active-low reset, every station is free, `iss_ready` is 1 and `disp_valid` is 0.
- R2: `iss_ready` is 0 exactly when all stations are occupied. An issue with `iss_valid` high while `iss_ready` is 0 is dropped and never dispatched.
- R3: A station with an operand still waiting on a producer is never dispatched.
- R4: A waiting operand whose tag equals `cdb_tag` while `cdb_valid` is 1 takes `cdb_data` at that clock edge. The station can then be dispatched from the next cycle on.
- R5: If an issued operand is marked pending (`iss_x_pend`=1) and a broadcast with the same tag occurs in the issue cycle, the broadcast value is stored directly and the operand is ready.
- R6: A station is freed only by a broadcast of its own destination tag after it has been dispatched. Dispatch alone does not free it, and `iss_ready` reflects the freed station in the cycle after the broadcast.
- R7: At most one station is dispatched per cycle. Among ready stations, the one issued earliest goes first.
- R8: While `disp_valid` is 1, `disp_op`, `disp_a`, `disp_b` and `disp_dst` carry the operation, the two operand values and the destination tag of the dispatched station.
- R9: `flush` empties all stations at the clock edge. An issue in the flush cycle is discarded, and `disp_valid` is 0 in the flush cycle.
- R10: While `fu_busy` is 1, `disp_valid` is 0 and ready stations stay waiting.
- R11: A station issued with both operands present (`iss_x_pend`=0) can be dispatched in the next cycle, with `disp_valid` rising combinationally in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flush | input | 1 | Empty every station |
| iss_valid | input | 1 | Issue request |
| iss_ready | output | 1 | A station is free; the issue is accepted |
| iss_op | input | OP_W | Operation code |
| iss_dst | input | TAG_W | Destination tag (reorder-buffer index) |
| iss_a_pend | input | 1 | Operand A waits on a producer |
| iss_a_tag | input | TAG_W | Producer tag of operand A |
| iss_a_val | input | DATA_W | Value of operand A when present |
| iss_b_pend | input | 1 | Operand B waits on a producer |
| iss_b_tag | input | TAG_W | Producer tag of operand B |
| iss_b_val | input | DATA_W | Value of operand B when present |
| cdb_valid | input | 1 | Result broadcast valid |
| cdb_tag | input | TAG_W | Tag of the broadcast result |
| cdb_data | input | DATA_W | Broadcast result value |
| fu_busy | input | 1 | Functional unit cannot accept work |
| disp_valid | output | 1 | A station is dispatched this cycle |
| disp_op | output | OP_W | Dispatched operation |
| disp_a | output | DATA_W | Dispatched operand A |
| disp_b | output | DATA_W | Dispatched operand B |
| disp_dst | output | TAG_W | Dispatched destination tag |

## Verification
A station whose operand state has gone wrong shows up as a wrong `disp_a`/`disp_b`, or as a missing dispatch, in the first cycle the station should have been eligible. That is one cycle after the broadcast or issue that should have made it ready. Corrupted age ordering shows up as the wrong `disp_dst` as soon as two stations are ready together. A station freed too early or too late shows up as `iss_ready` at the wrong level in the cycle after the broadcast, or when the pool fills.

// File: rtl/rs_pkg.sv
// Package: shared defaults and the station state encoding for the
// reservation station pool. Assumes all modules take their widths as
// parameters with these values as defaults.
package rs_pkg;
    localparam int unsigned RS_NUM_DEF  = 4;
    localparam int unsigned RS_OP_W_DEF = 4;
    localparam int unsigned RS_DATA_DEF = 32;
    localparam int unsigned RS_TAG_DEF  = 4;

    // Life cycle of one station
    typedef enum logic [1:0] {
        ST_FREE = 2'd0,   // holds nothing
        ST_WAIT = 2'd1,   // issued, waiting for operands or for dispatch
        ST_EXEC = 2'd2    // dispatched, waiting for its own result broadcast
    } rs_state_e;
endpackage

// File: rtl/rs_operand.sv
// Module: one source operand slot of a station.
// It stores either a value or the producer tag being waited on, snoops the
// result broadcast while pending, and bypasses a broadcast seen in the
// load cycle. Assumes load_i is high for exactly the issue cycle.
module rs_operand #(
    parameter int unsigned DATA_W = rs_pkg::RS_DATA_DEF,
    parameter int unsigned TAG_W  = rs_pkg::RS_TAG_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              pend_i,
    input  logic [TAG_W-1:0]  tag_i,
    input  logic [DATA_W-1:0] val_i,
    input  logic              cdb_valid_i,
    input  logic [TAG_W-1:0]  cdb_tag_i,
    input  logic [DATA_W-1:0] cdb_val_i,
    output logic              pend_o,
    output logic [DATA_W-1:0] val_o
);
    logic              pend_q;
    logic [TAG_W-1:0]  tag_q;
    logic [DATA_W-1:0] val_q;
    logic              hit_new;
    logic              hit_old;

    // Match the broadcast against the incoming tag and the stored tag
    always_comb begin
        hit_new = cdb_valid_i && (cdb_tag_i == tag_i);
        hit_old = cdb_valid_i && (cdb_tag_i == tag_q);
    end

    // Load at issue (with bypass) or capture a matching broadcast
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
            tag_q  <= '0;
            val_q  <= '0;
        end else if (load_i) begin
            tag_q <= tag_i;
            if (!pend_i) begin
                pend_q <= 1'b0;
                val_q  <= val_i;
            end else if (hit_new) begin
                pend_q <= 1'b0;
                val_q  <= cdb_val_i;
            end else begin
                pend_q <= 1'b1;
            end
        end else if (pend_q && hit_old) begin
            pend_q <= 1'b0;
            val_q  <= cdb_val_i;
        end
    end

    assign pend_o = pend_q;
    assign val_o  = val_q;

    AST_OPND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q && !load_i && !hit_old) |=> pend_q); // R4
    AST_OPND_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q && !load_i && hit_old) |=> (!pend_q && val_q == $past(cdb_val_i))); // R4
    AST_OPND_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && pend_i && hit_new) |=> !pend_q); // R5
endmodule

// File: rtl/rs_entry.sv
// Module: one reservation station.
// It holds the operation and destination tag, owns two operand slots,
// reports readiness, moves to the executing state when granted and frees
// itself on the broadcast of its own destination tag. Assumes destination
// tags of stations in flight are unique.
module rs_entry #(
    parameter int unsigned OP_W   = rs_pkg::RS_OP_W_DEF,
    parameter int unsigned DATA_W = rs_pkg::RS_DATA_DEF,
    parameter int unsigned TAG_W  = rs_pkg::RS_TAG_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush_i,
    input  logic              alloc_i,
    input  logic [OP_W-1:0]   op_i,
    input  logic [TAG_W-1:0]  dst_i,
    input  logic              a_pend_i,
    input  logic [TAG_W-1:0]  a_tag_i,
    input  logic [DATA_W-1:0] a_val_i,
    input  logic              b_pend_i,
    input  logic [TAG_W-1:0]  b_tag_i,
    input  logic [DATA_W-1:0] b_val_i,
    input  logic              cdb_valid_i,
    input  logic [TAG_W-1:0]  cdb_tag_i,
    input  logic [DATA_W-1:0] cdb_val_i,
    input  logic              grant_i,
    output logic              busy_o,
    output logic              ready_o,
    output logic [OP_W-1:0]   op_o,
    output logic [DATA_W-1:0] a_val_o,
    output logic [DATA_W-1:0] b_val_o,
    output logic [TAG_W-1:0]  dst_o
);
    import rs_pkg::*;

    rs_state_e        state_q;
    logic [OP_W-1:0]  op_q;
    logic [TAG_W-1:0] dst_q;
    logic             a_pend;
    logic             b_pend;
    logic             load;
    logic             done_hit;

    // Operand slots load only when this station is allocated
    assign load = alloc_i && !flush_i;

    rs_operand #(.DATA_W(DATA_W), .TAG_W(TAG_W)) u_opnd_a (
        .clk(clk), .rst_n(rst_n), .load_i(load),
        .pend_i(a_pend_i), .tag_i(a_tag_i), .val_i(a_val_i),
        .cdb_valid_i(cdb_valid_i), .cdb_tag_i(cdb_tag_i), .cdb_val_i(cdb_val_i),
        .pend_o(a_pend), .val_o(a_val_o)
    );

    rs_operand #(.DATA_W(DATA_W), .TAG_W(TAG_W)) u_opnd_b (
        .clk(clk), .rst_n(rst_n), .load_i(load),
        .pend_i(b_pend_i), .tag_i(b_tag_i), .val_i(b_val_i),
        .cdb_valid_i(cdb_valid_i), .cdb_tag_i(cdb_tag_i), .cdb_val_i(cdb_val_i),
        .pend_o(b_pend), .val_o(b_val_o)
    );

    // Detect the broadcast of this station's own result
    assign done_hit = (state_q == ST_EXEC) && cdb_valid_i && (cdb_tag_i == dst_q);

    // Station life cycle: free -> wait -> exec -> free
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_FREE;
            op_q    <= '0;
            dst_q   <= '0;
        end else if (flush_i) begin
            state_q <= ST_FREE;
        end else begin
            case (state_q)
                ST_FREE: if (alloc_i) begin
                    state_q <= ST_WAIT;
                    op_q    <= op_i;
                    dst_q   <= dst_i;
                end
                ST_WAIT: if (grant_i) state_q <= ST_EXEC;
                ST_EXEC: if (done_hit) state_q <= ST_FREE;
                default: state_q <= ST_FREE;
            endcase
        end
    end

    // Status and payload toward the pool
    always_comb begin
        busy_o  = (state_q != ST_FREE);
        ready_o = (state_q == ST_WAIT) && !a_pend && !b_pend;
        op_o    = op_q;
        dst_o   = dst_q;
    end

    AST_GRANT_ONLY_READY: assert property (@(posedge clk) disable iff (!rst_n)
        grant_i |-> (ready_o && !a_pend && !b_pend)); // R3
    AST_EXEC_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_EXEC) && !done_hit && !flush_i) |=> busy_o); // R6
    AST_FREE_ON_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        (done_hit && !flush_i) |=> !busy_o); // R6
    AST_NO_ALLOC_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_i |-> !busy_o); // R2
endmodule

// File: rtl/rs_age_select.sv
// Module: age matrix and oldest-ready picker.
// old_q[i][j] set means station i was issued before station j. On each
// allocation the new station becomes younger than all others. The grant
// goes to the ready station that no other ready station is older than.
// Assumes alloc_i is one-hot or zero.
module rs_age_select #(
    parameter int unsigned NUM = rs_pkg::RS_NUM_DEF
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NUM-1:0] alloc_i,
    input  logic [NUM-1:0] ready_i,
    input  logic           enable_i,
    output logic [NUM-1:0] grant_o
);
    logic [NUM-1:0] old_q [NUM];
    logic [NUM-1:0] beaten;

    // Update the age relation on every allocation
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM; i++) old_q[i] <= '0;
        end else begin
            for (int i = 0; i < NUM; i++) begin
                for (int j = 0; j < NUM; j++) begin
                    if (alloc_i[i]) old_q[i][j] <= 1'b0;
                    else if (alloc_i[j] && i != j) old_q[i][j] <= 1'b1;
                end
            end
        end
    end

    // A station loses if any other ready station is older
    always_comb begin
        beaten = '0;
        for (int i = 0; i < NUM; i++) begin
            for (int j = 0; j < NUM; j++) begin
                if (j != i && ready_i[j] && old_q[j][i]) beaten[i] = 1'b1;
            end
        end
        grant_o = enable_i ? (ready_i & ~beaten) : '0;
    end

    AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant_o)); // R7
    AST_READY_GETS_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        (enable_i && (|ready_i)) |-> ($countones(grant_o) == 1)); // R7
endmodule

// File: rtl/rs_pool.sv
// Module: top of the reservation station pool for one functional unit.
// It allocates the lowest-numbered free station on issue, forwards the
// broadcast bus to all stations, and muxes the oldest ready station to the
// dispatch port. Assumes one issue and one broadcast per cycle at most.
module rs_pool #(
    parameter int unsigned NUM_RS = rs_pkg::RS_NUM_DEF,
    parameter int unsigned OP_W   = rs_pkg::RS_OP_W_DEF,
    parameter int unsigned DATA_W = rs_pkg::RS_DATA_DEF,
    parameter int unsigned TAG_W  = rs_pkg::RS_TAG_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              iss_valid,
    output logic              iss_ready,
    input  logic [OP_W-1:0]   iss_op,
    input  logic [TAG_W-1:0]  iss_dst,
    input  logic              iss_a_pend,
    input  logic [TAG_W-1:0]  iss_a_tag,
    input  logic [DATA_W-1:0] iss_a_val,
    input  logic              iss_b_pend,
    input  logic [TAG_W-1:0]  iss_b_tag,
    input  logic [DATA_W-1:0] iss_b_val,
    input  logic              cdb_valid,
    input  logic [TAG_W-1:0]  cdb_tag,
    input  logic [DATA_W-1:0] cdb_data,
    input  logic              fu_busy,
    output logic              disp_valid,
    output logic [OP_W-1:0]   disp_op,
    output logic [DATA_W-1:0] disp_a,
    output logic [DATA_W-1:0] disp_b,
    output logic [TAG_W-1:0]  disp_dst
);
    logic [NUM_RS-1:0] busy;
    logic [NUM_RS-1:0] ready;
    logic [NUM_RS-1:0] alloc;
    logic [NUM_RS-1:0] grant;
    logic              iss_fire;
    logic              disp_en;
    logic              picked;

    logic [OP_W-1:0]   ent_op  [NUM_RS];
    logic [DATA_W-1:0] ent_a   [NUM_RS];
    logic [DATA_W-1:0] ent_b   [NUM_RS];
    logic [TAG_W-1:0]  ent_dst [NUM_RS];

    // Issue handshake: accepted when any station is free
    assign iss_ready = ~&busy;
    assign iss_fire  = iss_valid && iss_ready && !flush;
    assign disp_en   = !fu_busy && !flush;

    // Pick the lowest-numbered free station for the incoming issue
    always_comb begin
        alloc  = '0;
        picked = 1'b0;
        for (int i = 0; i < NUM_RS; i++) begin
            if (iss_fire && !busy[i] && !picked) begin
                alloc[i] = 1'b1;
                picked   = 1'b1;
            end
        end
    end

    for (genvar g = 0; g < NUM_RS; g++) begin : g_station
        rs_entry #(.OP_W(OP_W), .DATA_W(DATA_W), .TAG_W(TAG_W)) u_entry (
            .clk(clk), .rst_n(rst_n), .flush_i(flush), .alloc_i(alloc[g]),
            .op_i(iss_op), .dst_i(iss_dst),
            .a_pend_i(iss_a_pend), .a_tag_i(iss_a_tag), .a_val_i(iss_a_val),
            .b_pend_i(iss_b_pend), .b_tag_i(iss_b_tag), .b_val_i(iss_b_val),
            .cdb_valid_i(cdb_valid), .cdb_tag_i(cdb_tag), .cdb_val_i(cdb_data),
            .grant_i(grant[g]),
            .busy_o(busy[g]), .ready_o(ready[g]),
            .op_o(ent_op[g]), .a_val_o(ent_a[g]), .b_val_o(ent_b[g]),
            .dst_o(ent_dst[g])
        );
    end

    rs_age_select #(.NUM(NUM_RS)) u_age (
        .clk(clk), .rst_n(rst_n), .alloc_i(alloc), .ready_i(ready),
        .enable_i(disp_en), .grant_o(grant)
    );

    // Dispatch mux: OR of the granted station's payload
    always_comb begin
        disp_valid = |grant;
        disp_op    = '0;
        disp_a     = '0;
        disp_b     = '0;
        disp_dst   = '0;
        for (int i = 0; i < NUM_RS; i++) begin
            if (grant[i]) begin
                disp_op  = disp_op  | ent_op[i];
                disp_a   = disp_a   | ent_a[i];
                disp_b   = disp_b   | ent_b[i];
                disp_dst = disp_dst | ent_dst[i];
            end
        end
    end

    AST_FULL_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (&busy) |-> !iss_ready); // R2
    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (busy == '0)); // R9
    AST_FU_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        fu_busy |-> !disp_valid); // R10
    AST_ISSUE_OCCUPIES: assert property (@(posedge clk) disable iff (!rst_n)
        iss_fire |=> ($countones(busy) >= 1)); // R2
endmodule

// File: tb/rs_pool_bench.sv
// Bench: a cycle script of stimulus and expected outputs, then directed
// tests for flush, filling the pool and reset.
module rs_pool_bench;
    localparam int OP_W = 4, DW = 32, TW = 4;

    typedef struct packed {
        logic          iv;
        logic [OP_W-1:0] op;
        logic [TW-1:0] dst;
        logic          ap;
        logic [TW-1:0] at;
        logic [DW-1:0] av;
        logic          bp;
        logic [TW-1:0] bt;
        logic [DW-1:0] bv;
        logic          cv;
        logic [TW-1:0] ct;
        logic [DW-1:0] cd;
        logic          fb;
        logic          e_rdy;
        logic          e_dv;
        logic [OP_W-1:0] e_op;
        logic [TW-1:0] e_dst;
        logic [DW-1:0] e_a;
        logic [DW-1:0] e_b;
    } vec_t;

    // iv op dst ap at av bp bt bv cv ct cd fb | rdy dv op dst a b
    localparam vec_t VEC [12] = '{
        '{1'b1,4'd1,4'd1,1'b0,4'd0,32'd10,1'b0,4'd0,32'd20,1'b0,4'd0,32'd0,1'b0, 1'b1,1'b0,4'd0,4'd0,32'd0,32'd0},   // R11 issue A
        '{1'b1,4'd2,4'd2,1'b1,4'd5,32'd0,1'b0,4'd0,32'd7,1'b0,4'd0,32'd0,1'b0,   1'b1,1'b1,4'd1,4'd1,32'd10,32'd20}, // R8 A out
        '{1'b1,4'd3,4'd3,1'b0,4'd0,32'd1,1'b0,4'd0,32'd2,1'b1,4'd5,32'd55,1'b0,  1'b1,1'b0,4'd0,4'd0,32'd0,32'd0},   // R3 B waits
        '{1'b0,4'd0,4'd0,1'b0,4'd0,32'd0,1'b0,4'd0,32'd0,1'b0,4'd0,32'd0,1'b1,   1'b1,1'b0,4'd0,4'd0,32'd0,32'd0},   // R10 fu busy
        '{1'b0,4'd0,4'd0,1'b0,4'd0,32'd0,1'b0,4'd0,32'd0,1'b0,4'd0,32'd0,1'b0,   1'b1,1'b1,4'd2,4'd2,32'd55,32'd7},  // R7 R4 oldest B
        '{1'b0,4'd0,4'd0,1'b0,4'd0,32'd0,1'b0,4'd0,32'd0,1'b1,4'd1,32'd99,1'b0,  1'b1,1'b1,4'd3,4'd3,32'd1,32'd2},   // R7 C out
        '{1'b1,4'd4,4'd4,1'b1,4'd6,32'd0,1'b1,4'd7,32'd0,1'b1,4'd6,32'd66,1'b0,  1'b1,1'b0,4'd0,4'd0,32'd0,32'd0},   // R5 bypass
        '{1'b1,4'd5,4'd8,1'b0,4'd0,32'd3,1'b0,4'd0,32'd4,1'b0,4'd0,32'd0,1'b0,   1'b1,1'b0,4'd0,4'd0,32'd0,32'd0},   // R3 D waits
        '{1'b1,4'd6,4'd9,1'b0,4'd0,32'd8,1'b0,4'd0,32'd8,1'b0,4'd0,32'd0,1'b0,   1'b0,1'b1,4'd5,4'd8,32'd3,32'd4},   // R2 full
        '{1'b0,4'd0,4'd0,1'b0,4'd0,32'd0,1'b0,4'd0,32'd0,1'b1,4'd7,32'd77,1'b0,  1'b0,1'b0,4'd0,4'd0,32'd0,32'd0},   // R6 not freed
        '{1'b0,4'd0,4'd0,1'b0,4'd0,32'd0,1'b0,4'd0,32'd0,1'b1,4'd2,32'd5,1'b0,   1'b0,1'b1,4'd4,4'd4,32'd66,32'd77}, // R4 D out
        '{1'b0,4'd0,4'd0,1'b0,4'd0,32'd0,1'b0,4'd0,32'd0,1'b0,4'd0,32'd0,1'b0,   1'b1,1'b0,4'd0,4'd0,32'd0,32'd0}    // R6 R2 freed
    };

    logic clk = 1'b0, rst_n = 1'b0, flush = 1'b0;
    logic iss_valid = 1'b0, iss_ready;
    logic [OP_W-1:0] iss_op = '0;
    logic [TW-1:0] iss_dst = '0, iss_a_tag = '0, iss_b_tag = '0, cdb_tag = '0;
    logic iss_a_pend = 1'b0, iss_b_pend = 1'b0, cdb_valid = 1'b0, fu_busy = 1'b0;
    logic [DW-1:0] iss_a_val = '0, iss_b_val = '0, cdb_data = '0;
    logic disp_valid;
    logic [OP_W-1:0] disp_op;
    logic [DW-1:0] disp_a, disp_b;
    logic [TW-1:0] disp_dst;

    int errors = 0, checks = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    rs_pool u_rs_pool (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .iss_valid(iss_valid), .iss_ready(iss_ready), .iss_op(iss_op), .iss_dst(iss_dst),
        .iss_a_pend(iss_a_pend), .iss_a_tag(iss_a_tag), .iss_a_val(iss_a_val),
        .iss_b_pend(iss_b_pend), .iss_b_tag(iss_b_tag), .iss_b_val(iss_b_val),
        .cdb_valid(cdb_valid), .cdb_tag(cdb_tag), .cdb_data(cdb_data),
        .fu_busy(fu_busy), .disp_valid(disp_valid), .disp_op(disp_op),
        .disp_a(disp_a), .disp_b(disp_b), .disp_dst(disp_dst)
    );

    task automatic chk(input string req, input string what, input longint got, input longint exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
        end
    endtask

    task automatic idle();
        iss_valid = 1'b0; iss_a_pend = 1'b0; iss_b_pend = 1'b0;
        cdb_valid = 1'b0; fu_busy = 1'b0; flush = 1'b0;
    endtask

    task automatic issue(input logic [TW-1:0] dst, input logic ap, input logic [DW-1:0] av);
        iss_valid = 1'b1; iss_op = 4'd9; iss_dst = dst;
        iss_a_pend = ap; iss_a_tag = 4'd15; iss_a_val = av;
        iss_b_pend = 1'b0; iss_b_tag = 4'd0; iss_b_val = 32'd1;
    endtask

    initial begin
        repeat (10000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        idle();
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        #1;
        chk("R1", "iss_ready after reset", iss_ready, 1);
        chk("R1", "disp_valid after reset", disp_valid, 0);

        // Scripted cycle table
        for (int n = 0; n < 12; n++) begin
            @(negedge clk);
            iss_valid = VEC[n].iv; iss_op = VEC[n].op; iss_dst = VEC[n].dst;
            iss_a_pend = VEC[n].ap; iss_a_tag = VEC[n].at; iss_a_val = VEC[n].av;
            iss_b_pend = VEC[n].bp; iss_b_tag = VEC[n].bt; iss_b_val = VEC[n].bv;
            cdb_valid = VEC[n].cv; cdb_tag = VEC[n].ct; cdb_data = VEC[n].cd;
            fu_busy = VEC[n].fb;
            #1;
            chk("R2", $sformatf("vec %0d iss_ready", n), iss_ready, VEC[n].e_rdy);
            chk("R7", $sformatf("vec %0d disp_valid", n), disp_valid, VEC[n].e_dv);
            if (VEC[n].e_dv) begin
                chk("R8", $sformatf("vec %0d disp_dst", n), disp_dst, VEC[n].e_dst);
                chk("R8", $sformatf("vec %0d disp_op", n), disp_op, VEC[n].e_op);
                chk("R4", $sformatf("vec %0d disp_a", n), disp_a, VEC[n].e_a);
                chk("R5", $sformatf("vec %0d disp_b", n), disp_b, VEC[n].e_b);
            end
        end

        // R9: flush with fu busy and an issue in the same cycle
        @(negedge clk); idle(); fu_busy = 1'b1; issue(4'd10, 1'b0, 32'd5);
        @(negedge clk); idle(); fu_busy = 1'b1; flush = 1'b1; issue(4'd11, 1'b0, 32'd6);
        #1; chk("R9", "disp_valid in flush cycle", disp_valid, 0);
        @(negedge clk); idle();
        #1; chk("R9", "disp_valid after flush", disp_valid, 0);
        chk("R9", "iss_ready after flush", iss_ready, 1);

        // R9: flush with fu free still blocks dispatch in that cycle
        @(negedge clk); issue(4'd12, 1'b0, 32'd3);
        @(negedge clk); idle(); flush = 1'b1;
        #1; chk("R9", "no dispatch in flush cycle", disp_valid, 0);
        @(negedge clk); idle();
        #1; chk("R9", "flushed station gone", disp_valid, 0);

        // R2: fill all four stations with waiting operands
        for (int k = 0; k < 4; k++) begin
            @(negedge clk); idle(); issue(4'(k + 1), 1'b1, 32'd0);
            #1; chk("R2", $sformatf("ready while filling %0d", k), iss_ready, 1);
        end
        @(negedge clk); idle();
        #1; chk("R2", "ready low when full", iss_ready, 0);
        chk("R3", "no dispatch with pending operand", disp_valid, 0);

        // R1: reset in the middle of activity
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        #1; chk("R1", "iss_ready after mid reset", iss_ready, 1);
        chk("R1", "disp_valid after mid reset", disp_valid, 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule